// File: doc/BRIEF.md
# Reference-Compare Timer with Event Flags

This block is a 16-bit timer peripheral for a processor's register bus. A counter advances on a tick that comes either from every bus clock or from a divide-by-16 prescaler. On every tick the counter is compared with a programmable reference value. When the count equals the reference on a tick, a sticky match flag is set. If match interrupts are enabled, a level interrupt is raised while that flag is set. In restart mode the counter then returns to zero, so the count runs from 0 through the reference and one period is reference+1 ticks. Software that wants a period of N ticks therefore programs N-1. In free-run mode the counter keeps counting through 0xFFFF and wraps to 0. An external capture strobe sets a second sticky flag. Software clears either flag by writing a one to its bit.

Four registers are selected by `bus_addr`:
- 0 is the control register.
- 1 is the reference value.
- 2 is the live count, which can be read at any time.
- 3 holds the event flags.

Writes are single-cycle strobes. Read data is combinational from the addressed register.

The counting is governed by a two-state machine:
- OFF: disabled, with the counter frozen.
- RUN: counting.
- The START transition (OFF to RUN) is taken on a control write with the enable bit set. It clears the counter and the prescaler.
- The STOP transition (RUN to OFF) is taken on a control write with the enable bit clear. The counter keeps its value and does not advance on that edge.
- A control write that keeps the current enable value stays in the current state.

Top module: `cmp_timer`

## Requirements
- R1: After reset the control register reads 0, the count reads 0, the event register reads 0, the reference reads 0xFFFF and `irq` is low.
- R2: With control bit 0 (enable) and bit 2 (restart) set and bit 1 (slow clock) clear, the count advances on every clock and takes the values 0,1,...,REF,0,... The match flag (event bit 0) is set on the clock edge that ends the tick in which the count equals REF.
- R3: With control bit 1 set, the count advances once every 16 clocks. The first increment comes 16 clocks after the START edge, and with restart the match flag is set 16*(REF+1) clocks after START.
- R4: With restart clear, the count passes the reference without wrapping and wraps from 0xFFFF to 0. The match flag is set whenever the count equals REF on a tick.
- R5: The START transition clears the counter and the prescaler, so the count reads 0 right after it, whatever value was held before.
- R6: In state OFF the count holds its value and no match flag is set. The STOP edge itself does not advance the count.
- R7: `irq` is high exactly while event bit 0 is set and control bit 3 (match interrupt enable) is set. It is low in the cycle after a write that clears event bit 0.
- R8: A write to the event register clears each flag whose written bit is 1 and leaves flags whose written bit is 0 unchanged.
- R9: If a match and a clearing write of event bit 0 fall on the same edge, the flag stays set.
- R10: A one-cycle high on `capture_evt` sets event bit 1. That bit is cleared independently of bit 0 by writing 0x2.
- R11: The count is read live at address 2 while the timer runs. The reference (address 1) and the control register (address 0) read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register select: 0 control, 1 reference, 2 count, 3 events |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| capture_evt | input | 1 | Capture event strobe, sets event bit 1 |
| irq | output | 1 | Level match interrupt |

## Verification
The hardest case to reach from the ports is a flag-clearing write that lands on exactly the same edge as a hardware match. The stimulus reaches it by starting the timer at a known edge with a short reference in restart mode. Because the match edges then fall at predictable cycle offsets, the bench times its write to be captured on one of them. The free-run wrap through 0xFFFF is reached by letting the counter run a full 65536-tick lap from a known start. The slow-clock spacing is checked by sampling the count on both sides of the 16th clock after START.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    localparam int ADR_CTRL  = 0;
    localparam int ADR_REF   = 1;
    localparam int ADR_COUNT = 2;
    localparam int ADR_EVENT = 3;

    localparam int EV_MATCH = 0;
    localparam int EV_CAPT  = 1;
    localparam int EV_NUM   = 2;

    // Control register, bit 0 is enable.
    typedef struct packed {
        logic irq_en;
        logic restart;
        logic slow_clk;
        logic enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } run_state_e;

endpackage

// File: rtl/cmp_prescaler.sv
module cmp_prescaler #(
    parameter int PRE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic slow,
    output logic tick
);

    localparam logic [PRE_W-1:0] PRE_LAST = '1;

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = run && (!slow || (pre_q == PRE_LAST));

endmodule

// File: rtl/cmp_count_fsm.sv
module cmp_count_fsm
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             ctrl_wr_en,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] ref_val,
    output logic             run_on,
    output logic             start,
    output logic             match_pulse,
    output logic [CNT_W-1:0] count
);

    run_state_e state_q, state_d;
    logic       stop;
    logic       hit;
    logic       advance;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (ctrl_wr && ctrl_wr_en)  state_d = ST_RUN;
            ST_RUN: if (ctrl_wr && !ctrl_wr_en) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    assign run_on      = (state_q == ST_RUN);
    assign start       = (state_q == ST_OFF) && (state_d == ST_RUN);
    assign stop        = (state_q == ST_RUN) && (state_d == ST_OFF);
    assign hit         = (count == ref_val);
    assign advance     = run_on && !stop && tick;
    assign match_pulse = advance && hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (start) begin
            count <= '0;
        end else if (advance) begin
            count <= (hit && restart) ? '0 : count + 1'b1;
        end
    end

endmodule

// File: rtl/cmp_event_flags.sv
module cmp_event_flags #(
    parameter int N_EV = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_EV-1:0] set_vec,
    input  logic            clr_wr,
    input  logic [N_EV-1:0] clr_vec,
    output logic [N_EV-1:0] flags
);

    for (genvar i = 0; i < N_EV; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (set_vec[i]) begin
                flags[i] <= 1'b1;
            end else if (clr_wr && clr_vec[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 4,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              capture_evt,
    output logic              irq
);

    localparam logic [CNT_W-1:0] REF_RESET = '1;

    ctrl_t              ctrl_q;
    ctrl_t              ctrl_wdata;
    logic [CNT_W-1:0]   ref_q;
    logic [CNT_W-1:0]   count;
    logic [EV_NUM-1:0]  flags;
    logic [EV_NUM-1:0]  set_vec;
    logic               ctrl_wr;
    logic               ref_wr;
    logic               ev_wr;
    logic               tick;
    logic               run_on;
    logic               start;
    logic               match_pulse;

    assign ctrl_wr    = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL));
    assign ref_wr     = bus_wr && (bus_addr == ADDR_W'(ADR_REF));
    assign ev_wr      = bus_wr && (bus_addr == ADDR_W'(ADR_EVENT));
    assign ctrl_wdata = ctrl_t'(bus_wdata[CTRL_W-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ref_q  <= REF_RESET;
        end else begin
            if (ctrl_wr) ctrl_q <= ctrl_wdata;
            if (ref_wr)  ref_q  <= bus_wdata;
        end
    end

    cmp_prescaler #(
        .PRE_W (PRE_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .run   (run_on),
        .slow  (ctrl_q.slow_clk),
        .tick  (tick)
    );

    cmp_count_fsm #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .ctrl_wr_en  (ctrl_wdata.enable),
        .restart     (ctrl_q.restart),
        .tick        (tick),
        .ref_val     (ref_q),
        .run_on      (run_on),
        .start       (start),
        .match_pulse (match_pulse),
        .count       (count)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[EV_MATCH] = match_pulse;
        set_vec[EV_CAPT]  = capture_evt;
    end

    cmp_event_flags #(
        .N_EV (EV_NUM)
    ) u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_wr  (ev_wr),
        .clr_vec (bus_wdata[EV_NUM-1:0]),
        .flags   (flags)
    );

    assign irq = flags[EV_MATCH] && ctrl_q.irq_en;

    always_comb begin
        unique case (bus_addr)
            ADDR_W'(ADR_CTRL):  bus_rdata = CNT_W'(ctrl_q);
            ADDR_W'(ADR_REF):   bus_rdata = ref_q;
            ADDR_W'(ADR_COUNT): bus_rdata = count;
            default:            bus_rdata = CNT_W'(flags);
        endcase
    end

endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_on,
    input logic             restart,
    input logic             tick,
    input logic             ctrl_wr,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] ref_val,
    input logic             match_pulse,
    input logic             match_flag,
    input logic             ev_wr,
    input logic             ev_clr_match,
    input logic             irq
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    // R6
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_on && !ctrl_wr) |=> $stable(count));

    // R2
    restart_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_on && restart && tick && (count == ref_val) && !ctrl_wr) |=> (count == '0));

    // R4
    freerun_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_on && !restart && tick && (count == CNT_TOP) && !ctrl_wr) |=> (count == '0));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> match_flag);

    // R7
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wr && ev_clr_match && !match_pulse) |=> !irq);

endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_on       (run_on),
    .restart      (ctrl_q.restart),
    .tick         (tick),
    .ctrl_wr      (ctrl_wr),
    .count        (count),
    .ref_val      (ref_q),
    .match_pulse  (match_pulse),
    .match_flag   (flags[0]),
    .ev_wr        (ev_wr),
    .ev_clr_match (bus_wdata[0]),
    .irq          (irq)
);

// File: tb/test_cmp_timer.sv
`timescale 1ns/1ps
module test_cmp_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        capture_evt = 1'b0;
    logic        irq;

    cmp_timer i_cmp_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .capture_evt (capture_evt),
        .irq         (irq)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic        is_irq;
        logic [15:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    logic      chk_en = 1'b0;
    int        checks = 0;
    int        errors = 0;
    int        now    = 0;
    int        mark   = 0;
    logic      done   = 1'b0;

    // Monitor: pops one expectation per checked window
    always @(negedge clk) begin
        if (chk_en) begin
            exp_item_t it;
            logic [15:0] act;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: actual=%h expected=item", bus_rdata);
            end else begin
                it  = exp_q.pop_front();
                act = it.is_irq ? {15'd0, irq} : bus_rdata;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        now++;
    endtask

    task automatic at(input int k);
        while (now < mark + k) step();
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        step();
        bus_wr    = 1'b0;
    endtask

    task automatic check_rd(input logic [1:0] a, input logic [15:0] e, input string tag);
        exp_item_t it;
        it.is_irq = 1'b0;
        it.exp    = e;
        it.tag    = tag;
        exp_q.push_back(it);
        bus_addr = a;
        chk_en   = 1'b1;
        step();
        chk_en   = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string tag);
        exp_item_t it;
        it.is_irq = 1'b1;
        it.exp    = {15'd0, e};
        it.tag    = tag;
        exp_q.push_back(it);
        chk_en = 1'b1;
        step();
        chk_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        now   = 0;

        // R1 reset state
        check_rd(2'd0, 16'h0000, "R1 ctrl");
        check_rd(2'd2, 16'h0000, "R1 count");
        check_rd(2'd3, 16'h0000, "R1 events");
        check_rd(2'd1, 16'hFFFF, "R1 ref");
        check_irq(1'b0, "R1 irq");

        // Fast clock, restart, irq enabled, REF=4
        bus_write(2'd1, 16'd4);
        bus_write(2'd0, 16'h000D);
        mark = now;
        check_rd(2'd2, 16'd0, "R2 count0");
        check_rd(2'd2, 16'd1, "R11 live count");
        at(4); check_rd(2'd2, 16'd4, "R2 count at REF");
        check_rd(2'd3, 16'h0001, "R2 match flag");
        check_rd(2'd2, 16'd1, "R2 wrapped");
        check_irq(1'b1, "R7 irq high");
        at(8); bus_write(2'd3, 16'h0001);
        check_irq(1'b0, "R7 irq low after clear");
        at(14); bus_write(2'd3, 16'h0001);
        check_rd(2'd3, 16'h0001, "R9 set wins");
        bus_write(2'd3, 16'h0001);
        check_rd(2'd3, 16'h0000, "R8 cleared");
        bus_write(2'd0, 16'h0000);
        check_rd(2'd2, 16'd3, "R6 held at stop");
        at(23); check_rd(2'd2, 16'd3, "R6 still held");
        check_rd(2'd3, 16'h0000, "R6 no match while off");
        check_rd(2'd0, 16'h0000, "R11 ctrl readback");

        // Slow clock, restart, irq disabled, REF=2
        bus_write(2'd1, 16'd2);
        bus_write(2'd0, 16'h0007);
        mark = now;
        check_rd(2'd2, 16'd0, "R5 count cleared on start");
        at(15); check_rd(2'd2, 16'd0, "R3 before 16th clock");
        check_rd(2'd2, 16'd1, "R3 after 16th clock");
        at(47); check_rd(2'd3, 16'h0000, "R3 no early match");
        check_rd(2'd3, 16'h0001, "R3 match at 48");
        check_irq(1'b0, "R7 irq masked");
        check_rd(2'd2, 16'd0, "R3 wrapped");
        bus_write(2'd0, 16'h0000);
        bus_write(2'd3, 16'h0003);

        // Free-run, irq enabled, REF=3
        bus_write(2'd1, 16'd3);
        bus_write(2'd0, 16'h0009);
        mark = now;
        at(5); check_rd(2'd2, 16'd5, "R4 passes REF");
        check_rd(2'd3, 16'h0001, "R4 match in free-run");
        bus_write(2'd3, 16'h0000);
        check_rd(2'd3, 16'h0001, "R8 zero write keeps flag");
        bus_write(2'd3, 16'h0001);
        check_rd(2'd3, 16'h0000, "R8 one write clears");
        check_rd(2'd1, 16'd3, "R11 ref readback");
        at(65535); check_rd(2'd2, 16'hFFFF, "R4 top count");
        check_rd(2'd2, 16'h0000, "R4 wrap to zero");
        at(65540); check_rd(2'd3, 16'h0001, "R4 second match");
        capture_evt = 1'b1;
        step();
        capture_evt = 1'b0;
        check_rd(2'd3, 16'h0003, "R10 capture flag");
        bus_write(2'd3, 16'h0002);
        check_rd(2'd3, 16'h0001, "R10 capture cleared alone");

        step();
        if (exp_q.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard leftover: actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule